// File: doc/BRIEF.md
# Dual-Sample ADC Frame Serializer

This block puts two receive-channel converter results per symbol period onto one serial data line toward a signal processor. A free-running oversampling clock provides 48 bit slots per symbol period. A separate baud clock marks where each period begins. Two 14-bit two's-complement samples are handed over for each period: the primary once-per-symbol conversion and an extra conversion taken in the middle of the period.

Each sample is sent as a 16-bit word with its MSB first. The sample occupies the top 14 bits, and the two bottom bits are held low. Each word is followed by eight high filler bits. The first bit of a period is driven directly from the falling edge of the baud clock. Every later bit changes on a falling edge of the oversampling clock, so the receiver can capture each bit on a rising edge.

The samples are captured into a holding register when the period starts. If the valid input is low at that moment, the previous pair is sent again.

Top module: `adc_pair_serializer`

## Requirements
- R1: Out of reset and until the first falling baud edge that follows a sampled high baud level, the line stays high and no frame is sent.
- R2: At a falling baud edge, the line shows the MSB (sample bit 13) of the period's primary sample at once, without waiting for an oversampling clock edge.
- R3: Slots 0 to 13 carry primary sample bits 13 down to 0, MSB first. After slot 0, the line advances one slot on each falling oversampling clock edge.
- R4: Slots 14, 15, 38 and 39 (the two bottom bits of each 16-bit word) are always low.
- R5: Slots 16 to 23 and 40 to 47 are always high.
- R6: Slots 24 to 37 carry the mid-period sample, bits 13 down to 0, MSB first.
- R7: Changes on the sample and valid inputs after the period has started have no effect on the bits sent in that period.
- R8: When valid is low at a period start, the period repeats the most recently captured pair of samples.
- R9: When the next baud fall arrives later than 48 slots, the line stays high after slot 47 until that fall.
- R10: The codes for positive full scale (0x1FFF), midscale (0x0000) and negative full scale (0x2000), and all-ones (0x3FFF), pass through bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| os_clk | input | 1 | Oversampling bit clock, 48 ticks per symbol period |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_clk | input | 1 | Symbol clock; its falling edge starts a period |
| smp_valid | input | 1 | New sample pair present at period start |
| smp_main | input | 14 | Primary sample, two's complement |
| smp_mid | input | 14 | Mid-period sample, two's complement |
| sdo | output | 1 | Serial data line to the processor |

## Verification
There are three ways an internal state error can show. A slot counter that is off by one shifts every sample bit into a pad or filler slot; within the first period this shows as a low bit where a filler high is expected, or as a sample bit appearing in the wrong slot. A holding register that reloads mid-frame or on an invalid start shows up later in that same period, once the changed inputs reach a data slot. A counter that wraps instead of parking after slot 47 shows up in the first stretched gap, as a sample bit appearing before the baud fall.

// File: rtl/adc_pair_serializer.sv
module adc_pair_serializer #(
  parameter int SAMPLE_W = 14,
  parameter int WORD_W   = 16,
  parameter int GAP_W    = 8
) (
  input  logic                os_clk,
  input  logic                rst_n,
  input  logic                baud_clk,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_main,
  input  logic [SAMPLE_W-1:0] smp_mid,
  output logic                sdo
);
  localparam int HALF  = WORD_W + GAP_W;
  localparam int SLOTS = 2 * HALF;
  localparam int PAD   = WORD_W - SAMPLE_W;
  localparam int CW    = $clog2(SLOTS);
  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

  logic                baud_q, active;
  logic [CW-1:0]       slot, pos;
  logic [SAMPLE_W-1:0] hold_a, hold_b, cur;
  logic [WORD_W-1:0]   word_sh;
  logic                second, bit_v, first_msb;

  wire frame_start = baud_q & ~baud_clk;

  always_comb begin
    second  = slot >= CW'(HALF);
    pos     = second ? slot - CW'(HALF) : slot;
    cur     = second ? hold_b : hold_a;
    word_sh = {cur, {PAD{1'b0}}} << pos;
    bit_v   = (pos < CW'(WORD_W)) ? word_sh[WORD_W-1] : 1'b1;
  end

  assign first_msb = smp_valid ? smp_main[SAMPLE_W-1] : hold_a[SAMPLE_W-1];
  assign sdo = frame_start ? first_msb : (active ? bit_v : 1'b1);

  always_ff @(negedge os_clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q <= 1'b0;
      active <= 1'b0;
      slot   <= '0;
      hold_a <= '0;
      hold_b <= '0;
    end else begin
      baud_q <= baud_clk;
      if (frame_start) begin
        active <= 1'b1;
        slot   <= CW'(1);
        if (smp_valid) begin
          hold_a <= smp_main;
          hold_b <= smp_mid;
        end
      end else if (active && slot != LAST) begin
        slot <= slot + CW'(1);
      end
    end
  end

  a_r1_idle_high: assert property (@(negedge os_clk) disable iff (!rst_n)
    (!active && !frame_start) |-> sdo);

  a_r2_start_slot: assert property (@(negedge os_clk) disable iff (!rst_n)
    frame_start |=> (active && slot == CW'(1)));

  a_r3_slot_step: assert property (@(negedge os_clk) disable iff (!rst_n)
    (active && !frame_start && slot != LAST) |=> (slot == $past(slot) + CW'(1)));

  a_r4_pad_low: assert property (@(negedge os_clk) disable iff (!rst_n)
    (active && !frame_start && pos >= CW'(SAMPLE_W) && pos < CW'(WORD_W)) |-> !sdo);

  a_r7_hold_frozen: assert property (@(negedge os_clk) disable iff (!rst_n)
    (active && !frame_start) |=> ($stable(hold_a) && $stable(hold_b)));

  a_r8_repeat_held: assert property (@(negedge os_clk) disable iff (!rst_n)
    (frame_start && !smp_valid) |=> ($stable(hold_a) && $stable(hold_b)));

  a_r9_park_high: assert property (@(negedge os_clk) disable iff (!rst_n)
    (active && !frame_start && slot == LAST) |=> (slot == LAST && (frame_start || sdo)));
endmodule

// File: tb/adc_pair_serializer_bench.sv
module adc_pair_serializer_bench;
  logic        os_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baud_clk = 1'b1;
  logic        smp_valid = 1'b0;
  logic [13:0] smp_main = '0, smp_mid = '0;
  logic        sdo;

  int errors = 0, checks = 0;
  logic [13:0] held_a = '0, held_b = '0;

  always #5 os_clk = ~os_clk;

  adc_pair_serializer u_adc_pair_serializer (
    .os_clk(os_clk), .rst_n(rst_n), .baud_clk(baud_clk), .smp_valid(smp_valid),
    .smp_main(smp_main), .smp_mid(smp_mid), .sdo(sdo));

  task automatic chk(input logic got, input logic exp, input string req, input int k);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s slot %0d: got %b expected %b", req, k, got, exp);
    end
  endtask

  function automatic string tag_of(int k);
    int p = k % 24;
    if (p < 14) return (k >= 24) ? "R6" : "R3";
    if (p < 16) return "R4";
    return "R5";
  endfunction

  task automatic run_period(input logic [13:0] a, input logic [13:0] b, input logic v,
                            input bit corrupt, input int extra, input string tag);
    logic [47:0] frame;
    @(negedge os_clk); #1;
    smp_main = a; smp_mid = b; smp_valid = v; baud_clk = 1'b0;
    if (v) begin held_a = a; held_b = b; end
    frame = {held_a, 2'b00, 8'hFF, held_b, 2'b00, 8'hFF};
    #1 chk(sdo, frame[47], (tag == "") ? "R2" : tag, 0);
    for (int k = 0; k < 48; k++) begin
      @(posedge os_clk); #1;
      chk(sdo, frame[47-k], (tag == "") ? tag_of(k) : tag, k);
      if (k == 24) baud_clk = 1'b1;
      if (corrupt && k == 10) begin
        smp_main = ~a; smp_mid = ~b; smp_valid = 1'b1;
      end
    end
    for (int e = 0; e < extra; e++) begin
      @(posedge os_clk); #1;
      chk(sdo, 1'b1, "R9", 48 + e);
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge os_clk);
    #1 chk(sdo, 1'b1, "R1", -1);
    baud_clk = 1'b0;
    @(posedge os_clk); #1 rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge os_clk); #1 chk(sdo, 1'b1, "R1", -1);
    end
    baud_clk = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge os_clk); #1 chk(sdo, 1'b1, "R1", -1);
    end

    for (int i = 0; i < 14; i++)
      run_period(14'(1 << i), ~14'(1 << i), 1'b1, 1'b0, 0, "");

    run_period(14'h1FFF, 14'h2000, 1'b1, 1'b0, 0, "R10");
    run_period(14'h2000, 14'h1FFF, 1'b1, 1'b0, 0, "R10");
    run_period(14'h0000, 14'h3FFF, 1'b1, 1'b0, 0, "R10");

    run_period(14'h2A5C, 14'h15A3, 1'b1, 1'b1, 0, "R7");
    run_period(14'h0F0F, 14'h30F0, 1'b1, 1'b1, 0, "R7");

    run_period(14'h1111, 14'h2222, 1'b0, 1'b0, 0, "R8");
    run_period(14'h3333, 14'h0444, 1'b0, 1'b1, 0, "R8");

    run_period(14'h1ABC, 14'h2DEF, 1'b1, 1'b0, 7, "");
    run_period(14'h0001, 14'h2000, 1'b1, 1'b0, 3, "");

    for (int i = 0; i < 40; i++) begin
      logic [13:0] a = 14'(i * 753 + 5);
      run_period(a, a ^ 14'h155A, 1'b1, 1'b0, (i % 5 == 0) ? 2 : 0, "");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule